// File: doc/BRIEF.md
# EDO DRAM Module Controller

This block sits between a 32-bit host port and a 72-pin EDO DRAM module built from 4M×4 devices. A host request carries a word address, a write flag, write data and four byte enables. The controller turns each request into one complete row/column strobe sequence on the module. The row and then the column go out on the 11 multiplexed address pins. Read data comes back to the host with a single-cycle valid pulse.

The word address is split into a column (low 11 bits), a row (next 11 bits) and a side bit (top bit). Each module side has a strobe line for the low half-word and one for the high half-word. The controller lowers only the row strobes whose half carries an enabled byte, and only the column strobes of enabled bytes. Data pins are shared between input and output, so every write is an early write. A refresh scheduler outside the block asks for CAS-before-RAS refresh cycles. Those requests win over host requests at a cycle boundary, but they never cut into a cycle already running. All timing is given in clock cycles through parameters.

Top module: `edo_dram_ctrl`

## Requirements
- R1: While reset is active and right after it, all row and column strobes are high, write enable is high, the data output enable is low, and `rvalid` and `ref_ack` are low.
- R2: The word address is {side, row, column}: `req_addr[22]` is the side, `req_addr[21:11]` the row and `req_addr[10:0]` the column. The row is on `dram_addr` when the row strobes fall. The column is on `dram_addr` while the column strobes are low.
- R3: Row strobe line index = 2×half + side. Line 0 is side 0 low half (bytes 0–1), line 1 is side 1 low half, line 2 is side 0 high half (bytes 2–3), line 3 is side 1 high half. A line is driven low (active) only when its side matches and its half has an enabled byte.
- R4: Column strobe k drives byte k (`dq[8k+7:8k]`) and goes low only when `req_be[k]` is 1. On a write, bytes whose enable is 0 keep their stored value.
- R5: Writes are early writes. Write enable goes low together with the row strobes, while all column strobes are still high. The data output enable is high only while write enable is low. Write enable stays high for reads and refresh.
- R6: A read returns the word present on `dram_dq_in` at the end of the column phase. `rdata` is valid during a one-cycle `rvalid` pulse, which comes RCD + column-phase cycles after the row strobes fall.
- R7: Row strobes fall with the row address. The column strobes fall `P_RCD_CYC` cycles later. The row strobes stay low for at least `P_RAS_MIN_CYC` cycles and stay high for at least `P_RP_CYC` cycles. Consecutive row strobe falls are at least `P_RC_CYC` cycles apart. With the defaults the column phase lasts 2 cycles and precharge lasts 3.
- R8: In a refresh cycle all four column strobes go low at least `P_CSR_CYC` cycles before all four row strobes go low. Write enable stays high for the whole refresh.
- R9: When `ref_req` is high, `req_ready` is low. A refresh request raised during a host cycle waits until that cycle, including its precharge, has finished.
- R10: `ref_ack` pulses for one cycle when a refresh cycle is accepted, together with the column strobes falling.
- R11: The row strobes never stay low longer than `P_RAS_MAX_CYC` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller accepts a host request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 23 | Word address {side, row, column} |
| req_be | input | 4 | Byte enables |
| req_wdata | input | 32 | Write data |
| rvalid | output | 1 | Read data valid pulse |
| rdata | output | 32 | Read data |
| ref_req | input | 1 | Refresh request level from the scheduler |
| ref_ack | output | 1 | Refresh accepted pulse |
| dram_addr | output | 11 | Multiplexed row/column address |
| dram_ras_n | output | 4 | Row strobes, active low |
| dram_cas_n | output | 4 | Column strobes, active low, one per byte |
| dram_we_n | output | 1 | Write enable, active low |
| dram_dq_out | output | 32 | Data driven toward the module |
| dram_dq_oe | output | 1 | Output enable for `dram_dq_out` |
| dram_dq_in | input | 32 | Data returned by the module |

## Verification
The assertions assume that a host request holds its fields steady until `req_ready` accepts it. They also assume at least one byte enable is set and that `ref_req` stays high until `ref_ack`. The directed tasks drive every request on the falling clock edge. Each task holds the request until it is accepted, and always drops `ref_req` right after the acknowledge. A small behavioural memory in the bench latches the row and column from the strobe edges. It drives read data only while a column strobe is low, so the data returned depends on the pins the design actually drives.

// File: rtl/edoc_pkg.sv
package edoc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_ROW     = 3'd1,
    ST_COL     = 3'd2,
    ST_PRE     = 3'd3,
    ST_CBR_CAS = 3'd4,
    ST_CBR_RAS = 3'd5
  } edoc_state_e;

  function automatic int unsigned edoc_max(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/edoc_lane_map.sv
module edoc_lane_map #(
  parameter int unsigned P_LANES = 4
) (
  input  logic               side,
  input  logic [P_LANES-1:0] be,
  output logic [3:0]         ras_sel,
  output logic [P_LANES-1:0] cas_sel
);
  localparam int unsigned HALVES    = 2;
  localparam int unsigned SIDES     = 2;
  localparam int unsigned HALF_BYTE = P_LANES / HALVES;

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    for (genvar s = 0; s < SIDES; s++) begin : g_side
      assign ras_sel[h*SIDES + s] = (side == 1'(s)) && (|be[h*HALF_BYTE +: HALF_BYTE]);
    end
  end

  assign cas_sel = be;

endmodule

// File: rtl/edoc_seq.sv
module edoc_seq
  import edoc_pkg::*;
#(
  parameter int unsigned P_RCD     = 1,
  parameter int unsigned P_COL     = 2,
  parameter int unsigned P_PRE     = 3,
  parameter int unsigned P_CSR     = 1,
  parameter int unsigned P_RAS_MIN = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        ref_req,
  output edoc_state_e state_q,
  output edoc_state_e state_d,
  output logic        host_go,
  output logic        ref_go,
  output logic        ready
);
  localparam int unsigned LONGEST =
    edoc_max(edoc_max(edoc_max(P_RCD, P_COL), edoc_max(P_PRE, P_CSR)), P_RAS_MIN);
  localparam int unsigned CNT_W = $clog2(LONGEST + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_done;

  assign cnt_done = (cnt_q == '0);
  assign ready    = (state_q == ST_IDLE) && !ref_req;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_done ? cnt_q : cnt_q - 1'b1;
    host_go = 1'b0;
    ref_go  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (ref_req) begin
          state_d = ST_CBR_CAS;
          cnt_d   = CNT_W'(P_CSR - 1);
          ref_go  = 1'b1;
        end else if (req_valid) begin
          state_d = ST_ROW;
          cnt_d   = CNT_W'(P_RCD - 1);
          host_go = 1'b1;
        end
      end
      ST_ROW: if (cnt_done) begin
        state_d = ST_COL;
        cnt_d   = CNT_W'(P_COL - 1);
      end
      ST_COL: if (cnt_done) begin
        state_d = ST_PRE;
        cnt_d   = CNT_W'(P_PRE - 1);
      end
      ST_PRE: if (cnt_done) state_d = ST_IDLE;
      ST_CBR_CAS: if (cnt_done) begin
        state_d = ST_CBR_RAS;
        cnt_d   = CNT_W'(P_RAS_MIN - 1);
      end
      ST_CBR_RAS: if (cnt_done) begin
        state_d = ST_PRE;
        cnt_d   = CNT_W'(P_PRE - 1);
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

endmodule

// File: rtl/edo_dram_ctrl.sv
module edo_dram_ctrl
  import edoc_pkg::*;
#(
  parameter int unsigned P_COL_W       = 11,
  parameter int unsigned P_ROW_W       = 11,
  parameter int unsigned P_DATA_W      = 32,
  parameter int unsigned P_RCD_CYC     = 1,
  parameter int unsigned P_CAC_CYC     = 1,
  parameter int unsigned P_RAC_CYC     = 3,
  parameter int unsigned P_CAS_MIN_CYC = 1,
  parameter int unsigned P_RAS_MIN_CYC = 3,
  parameter int unsigned P_RP_CYC      = 2,
  parameter int unsigned P_RC_CYC      = 6,
  parameter int unsigned P_CSR_CYC     = 1,
  parameter int unsigned P_RAS_MAX_CYC = 500
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic                       req_write,
  input  logic [P_COL_W+P_ROW_W:0]   req_addr,
  input  logic [P_DATA_W/8-1:0]      req_be,
  input  logic [P_DATA_W-1:0]        req_wdata,
  output logic                       rvalid,
  output logic [P_DATA_W-1:0]        rdata,
  input  logic                       ref_req,
  output logic                       ref_ack,
  output logic [P_COL_W-1:0]         dram_addr,
  output logic [3:0]                 dram_ras_n,
  output logic [P_DATA_W/8-1:0]      dram_cas_n,
  output logic                       dram_we_n,
  output logic [P_DATA_W-1:0]        dram_dq_out,
  output logic                       dram_dq_oe,
  input  logic [P_DATA_W-1:0]        dram_dq_in
);
  localparam int unsigned LANES   = P_DATA_W / 8;
  localparam int unsigned ADDR_W  = P_COL_W + P_ROW_W + 1;
  localparam int unsigned RAC_REM = (P_RAC_CYC > P_RCD_CYC) ? P_RAC_CYC - P_RCD_CYC : 1;
  localparam int unsigned RAS_REM = (P_RAS_MIN_CYC > P_RCD_CYC) ? P_RAS_MIN_CYC - P_RCD_CYC : 1;
  localparam int unsigned COL_CYC =
    edoc_max(edoc_max(P_CAS_MIN_CYC, P_CAC_CYC), edoc_max(RAC_REM, RAS_REM));
  localparam int unsigned RC_REM  =
    (P_RC_CYC > P_RCD_CYC + COL_CYC) ? P_RC_CYC - P_RCD_CYC - COL_CYC : 1;
  localparam int unsigned PRE_CYC = edoc_max(P_RP_CYC, RC_REM);

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  edoc_state_e state_q, state_d;
  logic        host_go, ref_go;

  edoc_seq #(
    .P_RCD     (P_RCD_CYC),
    .P_COL     (COL_CYC),
    .P_PRE     (PRE_CYC),
    .P_CSR     (P_CSR_CYC),
    .P_RAS_MIN (P_RAS_MIN_CYC)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .req_valid (req_valid),
    .ref_req   (ref_req),
    .state_q   (state_q),
    .state_d   (state_d),
    .host_go   (host_go),
    .ref_go    (ref_go),
    .ready     (req_ready)
  );

  // request holding registers
  logic               wr_q, side_q;
  logic [P_ROW_W-1:0] row_q;
  logic [P_COL_W-1:0] col_q;
  logic [LANES-1:0]   be_q;

  logic               cur_wr, cur_side;
  logic [P_ROW_W-1:0] cur_row;
  logic [P_COL_W-1:0] cur_col;
  logic [LANES-1:0]   cur_be;

  assign cur_wr   = host_go ? req_write                     : wr_q;
  assign cur_side = host_go ? req_addr[ADDR_W-1]            : side_q;
  assign cur_row  = host_go ? req_addr[P_COL_W +: P_ROW_W]  : row_q;
  assign cur_col  = host_go ? req_addr[P_COL_W-1:0]         : col_q;
  assign cur_be   = host_go ? req_be                        : be_q;

  logic [3:0]       ras_sel;
  logic [LANES-1:0] cas_sel;

  edoc_lane_map #(.P_LANES(LANES)) u_lane (
    .side    (cur_side),
    .be      (cur_be),
    .ras_sel (ras_sel),
    .cas_sel (cas_sel)
  );

  // next values of the pin registers, from the next state
  logic [3:0]         ras_n_d;
  logic [LANES-1:0]   cas_n_d;
  logic [P_COL_W-1:0] addr_d;
  logic               we_n_d, oe_d, rd_capture;

  always_comb begin
    ras_n_d = '1;
    cas_n_d = '1;
    we_n_d  = 1'b1;
    oe_d    = 1'b0;
    addr_d  = dram_addr;
    unique case (state_d)
      ST_ROW: begin
        ras_n_d = ~ras_sel;
        addr_d  = P_COL_W'(cur_row);
        we_n_d  = ~cur_wr;
        oe_d    = cur_wr;
      end
      ST_COL: begin
        ras_n_d = ~ras_sel;
        cas_n_d = ~cas_sel;
        addr_d  = cur_col;
        we_n_d  = ~cur_wr;
        oe_d    = cur_wr;
      end
      ST_CBR_CAS: cas_n_d = '0;
      ST_CBR_RAS: begin
        ras_n_d = '0;
        cas_n_d = '0;
      end
      default: ;
    endcase
  end

  assign rd_capture = (state_q == ST_COL) && (state_d == ST_PRE) && !wr_q;

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      wr_q        <= 1'b0;
      side_q      <= 1'b0;
      row_q       <= '0;
      col_q       <= '0;
      be_q        <= '0;
      dram_dq_out <= '0;
      dram_addr   <= '0;
      dram_ras_n  <= '1;
      dram_cas_n  <= '1;
      dram_we_n   <= 1'b1;
      dram_dq_oe  <= 1'b0;
      rvalid      <= 1'b0;
      rdata       <= '0;
      ref_ack     <= 1'b0;
    end else begin
      if (host_go) begin
        wr_q        <= req_write;
        side_q      <= req_addr[ADDR_W-1];
        row_q       <= req_addr[P_COL_W +: P_ROW_W];
        col_q       <= req_addr[P_COL_W-1:0];
        be_q        <= req_be;
        dram_dq_out <= req_wdata;
      end
      if (rd_capture) rdata <= dram_dq_in;
      dram_addr  <= addr_d;
      dram_ras_n <= ras_n_d;
      dram_cas_n <= cas_n_d;
      dram_we_n  <= we_n_d;
      dram_dq_oe <= oe_d;
      rvalid     <= rd_capture;
      ref_ack    <= ref_go;
    end
  end

endmodule

// File: rtl/edo_dram_ctrl_chk.sv
module edo_dram_ctrl_chk #(
  parameter int unsigned P_RAS_MIN = 3,
  parameter int unsigned P_RP      = 2,
  parameter int unsigned P_RAS_MAX = 500
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_ready,
  input logic       ref_req,
  input logic       rvalid,
  input logic [3:0] ras_n,
  input logic [3:0] cas_n,
  input logic       we_n,
  input logic       dq_oe
);
  logic [15:0] lo_cnt, hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_cnt <= '0;
      hi_cnt <= 16'(P_RP);
    end else begin
      if (ras_n != 4'hF) begin
        lo_cnt <= (lo_cnt == 16'hFFFF) ? lo_cnt : lo_cnt + 16'd1;
        hi_cnt <= '0;
      end else begin
        lo_cnt <= '0;
        hi_cnt <= (hi_cnt == 16'hFFFF) ? hi_cnt : hi_cnt + 16'd1;
      end
    end
  end

  p_oe_needs_we_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> !we_n);

  p_we_falls_cas_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(we_n) |-> (cas_n == 4'hF));

  p_cbr_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ras_n) == 4'hF && ras_n != 4'hF && cas_n != 4'hF)
      |-> ($past(cas_n) == 4'h0 && we_n && $past(we_n)));

  p_rvalid_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |=> !rvalid);

  p_ras_low_min_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ras_n) != 4'hF && ras_n == 4'hF) |-> (lo_cnt >= 16'(P_RAS_MIN)));

  p_precharge_min_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ras_n) == 4'hF && ras_n != 4'hF) |-> (hi_cnt >= 16'(P_RP)));

  p_ras_low_max_r11: assert property (@(posedge clk) disable iff (!rst_n)
    lo_cnt <= 16'(P_RAS_MAX));

  p_ready_blocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ref_req |-> !req_ready);

endmodule

bind edo_dram_ctrl edo_dram_ctrl_chk #(
  .P_RAS_MIN (P_RAS_MIN_CYC),
  .P_RP      (P_RP_CYC),
  .P_RAS_MAX (P_RAS_MAX_CYC)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .ref_req   (ref_req),
  .rvalid    (rvalid),
  .ras_n     (dram_ras_n),
  .cas_n     (dram_cas_n),
  .we_n      (dram_we_n),
  .dq_oe     (dram_dq_oe)
);

// File: tb/edo_dram_ctrl_tb.sv
module edo_dram_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, ref_req = 1'b0;
  logic [22:0] req_addr = '0;
  logic [3:0]  req_be = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rvalid, ref_ack, dram_we_n, dram_dq_oe;
  logic [31:0] rdata, dram_dq_out, dram_dq_in;
  logic [10:0] dram_addr;
  logic [3:0]  dram_ras_n, dram_cas_n;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  edo_dram_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .rvalid(rvalid), .rdata(rdata), .ref_req(ref_req), .ref_ack(ref_ack),
    .dram_addr(dram_addr), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
    .dram_we_n(dram_we_n), .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe),
    .dram_dq_in(dram_dq_in)
  );

  // behavioural module memory, 16 words indexed by {side,row[0],col[1:0]}
  logic [31:0] mem [16];
  logic [31:0] shadow [16];
  logic [10:0] m_row = '0;
  logic        m_side = 1'b0;
  logic [3:0]  p_ras = 4'hF, p_cas = 4'hF;

  function automatic int idx(input logic s, input logic [10:0] r, input logic [10:0] c);
    return {28'd0, s, r[0], c[1:0]};
  endfunction

  always @(posedge clk) begin
    if (p_ras == 4'hF && dram_ras_n != 4'hF && dram_cas_n == 4'hF) begin
      m_row  <= dram_addr;
      m_side <= ~dram_ras_n[1] | ~dram_ras_n[3];
    end
    if (p_cas == 4'hF && dram_cas_n != 4'hF && dram_ras_n != 4'hF && !dram_we_n) begin
      for (int k = 0; k < 4; k++)
        if (!dram_cas_n[k]) mem[idx(m_side, m_row, dram_addr)][8*k +: 8] <= dram_dq_out[8*k +: 8];
    end
    p_ras <= dram_ras_n;
    p_cas <= dram_cas_n;
  end

  always_comb begin
    if (dram_ras_n != 4'hF && dram_cas_n != 4'hF && dram_we_n)
      dram_dq_in = mem[idx(m_side, m_row, dram_addr)];
    else
      dram_dq_in = 32'h0;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // pin timing monitor (R7, R11)
  int lo = 0, hi = 100, rf = 0, ff = 100;
  logic [3:0] m_pr = 4'hF, m_pc = 4'hF;
  always @(negedge clk) begin
    if (rst_n) begin
      if (m_pr != 4'hF && dram_ras_n == 4'hF) begin
        check(lo >= 3, "R7 ras low min", lo, 3);
        check(lo <= 500, "R11 ras low max", lo, 500);
      end
      if (m_pr == 4'hF && dram_ras_n != 4'hF) begin
        check(hi >= 2, "R7 precharge min", hi, 2);
        check(ff >= 6, "R7 cycle min", ff, 6);
        rf = 0; ff = 0;
      end else begin
        rf++; ff++;
      end
      if (m_pc == 4'hF && dram_cas_n != 4'hF && dram_ras_n != 4'hF && m_pr != 4'hF)
        check(rf == 1, "R7 ras-to-cas", rf, 1);
      if (dram_ras_n != 4'hF) begin lo++; hi = 0; end else begin hi++; lo = 0; end
      m_pr = dram_ras_n;
      m_pc = dram_cas_n;
    end
  end

  function automatic logic [3:0] exp_ras(input logic s, input logic [3:0] be);
    logic [3:0] a;
    a[0] = !s && (be[0] || be[1]);
    a[1] =  s && (be[0] || be[1]);
    a[2] = !s && (be[2] || be[3]);
    a[3] =  s && (be[2] || be[3]);
    return ~a;
  endfunction

  task automatic wait_ready();
    while (!req_ready) @(negedge clk);
  endtask

  // drives a request; returns at the negedge where the row strobes are low
  task automatic host_req(input bit wr, input bit s, input logic [10:0] r, input logic [10:0] c,
                          input logic [3:0] be, input logic [31:0] wd);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = {s, r, c}; req_be = be; req_wdata = wd;
    wait_ready();
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(dram_ras_n == 4'hF && dram_cas_n == 4'hF, "R1 strobes in reset", {dram_ras_n, dram_cas_n}, 8'hFF);
    check(dram_we_n && !dram_dq_oe && !rvalid && !ref_ack, "R1 controls in reset",
          {dram_we_n, dram_dq_oe, rvalid, ref_ack}, 4'b1000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(dram_ras_n == 4'hF && dram_cas_n == 4'hF && dram_we_n, "R1 idle after reset",
          {dram_ras_n, dram_cas_n, dram_we_n}, 9'h1FF);
  endtask

  task automatic t_write(input bit s, input logic [10:0] r, input logic [10:0] c,
                         input logic [3:0] be, input logic [31:0] wd);
    host_req(1'b1, s, r, c, be, wd);
    check(dram_ras_n == exp_ras(s, be), "R3 row strobe select", dram_ras_n, exp_ras(s, be));
    check(dram_addr == r, "R2 row address", dram_addr, r);
    check(!dram_we_n && dram_cas_n == 4'hF, "R5 early write enable", {dram_we_n, dram_cas_n}, 5'h0F);
    @(negedge clk);
    check(dram_cas_n == ~be, "R4 column strobes", dram_cas_n, ~be);
    check(dram_addr == c, "R2 column address", dram_addr, c);
    check(dram_dq_oe && dram_dq_out == wd, "R5 write data driven", dram_dq_out, wd);
    for (int k = 0; k < 4; k++)
      if (be[k]) shadow[idx(s, r, c)][8*k +: 8] = wd[8*k +: 8];
    wait_ready();
  endtask

  task automatic t_read(input bit s, input logic [10:0] r, input logic [10:0] c, input logic [3:0] be);
    host_req(1'b0, s, r, c, be, 32'h0);
    check(dram_we_n && !dram_dq_oe, "R5 read keeps we high", {dram_we_n, dram_dq_oe}, 2'b10);
    check(dram_ras_n == exp_ras(s, be), "R3 row strobe select read", dram_ras_n, exp_ras(s, be));
    @(negedge clk);
    check(dram_cas_n == ~be && dram_addr == c, "R2 read column", {dram_cas_n, dram_addr}, {~be, c});
    @(negedge clk);
    check(!rvalid, "R6 no early rvalid", rvalid, 0);
    @(negedge clk);
    check(rvalid && rdata == shadow[idx(s, r, c)], "R6 read data", rdata, shadow[idx(s, r, c)]);
    @(negedge clk);
    check(!rvalid, "R6 rvalid single pulse", rvalid, 0);
    wait_ready();
  endtask

  task automatic t_refresh();
    @(negedge clk);
    ref_req = 1'b1;
    #1;
    check(!req_ready, "R9 ready low on refresh", req_ready, 0);
    @(posedge clk);
    @(negedge clk);
    check(ref_ack && dram_cas_n == 4'h0 && dram_ras_n == 4'hF, "R10 ack with cas first",
          {ref_ack, dram_cas_n, dram_ras_n}, 9'h10F);
    check(dram_we_n, "R8 we high in refresh", dram_we_n, 1);
    ref_req = 1'b0;
    @(negedge clk);
    check(dram_ras_n == 4'h0 && dram_cas_n == 4'h0 && !ref_ack, "R8 ras after cas",
          {dram_ras_n, dram_cas_n, ref_ack}, 9'h000);
    check(dram_we_n, "R8 we high during ras", dram_we_n, 1);
    wait_ready();
  endtask

  task automatic t_priority();
    @(negedge clk);
    ref_req = 1'b1;
    req_valid = 1'b1; req_write = 1'b0; req_addr = {1'b0, 11'd4, 11'd1}; req_be = 4'hF;
    @(posedge clk);
    @(negedge clk);
    check(ref_ack && dram_ras_n == 4'hF, "R9 refresh wins", {ref_ack, dram_ras_n}, 5'h1F);
    ref_req = 1'b0;
    wait_ready();
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check(dram_ras_n == 4'b1010 && dram_addr == 11'd4, "R9 host after refresh",
          {dram_ras_n, dram_addr}, {4'b1010, 11'd4});
    repeat (3) @(negedge clk);
    check(rvalid && rdata == shadow[idx(0, 11'd4, 11'd1)], "R9 host read data", rdata,
          shadow[idx(0, 11'd4, 11'd1)]);
    wait_ready();
  endtask

  task automatic t_no_interrupt();
    bit seen;
    host_req(1'b0, 1'b1, 11'd3, 11'd2, 4'hF, 32'h0);
    ref_req = 1'b1;
    repeat (3) begin
      check(!ref_ack && dram_ras_n == 4'b0101, "R9 host cycle not cut", {ref_ack, dram_ras_n}, 5'h05);
      if (!rvalid) @(negedge clk);
    end
    check(rvalid && rdata == shadow[idx(1, 11'd3, 11'd2)], "R9 read completes", rdata,
          shadow[idx(1, 11'd3, 11'd2)]);
    seen = 1'b0;
    for (int i = 0; i < 10 && !seen; i++) begin
      @(negedge clk);
      if (ref_ack) seen = 1'b1;
      else check(dram_cas_n == 4'hF, "R9 no refresh during precharge", dram_cas_n, 4'hF);
    end
    check(seen, "R10 deferred refresh acked", seen, 1);
    ref_req = 1'b0;
    wait_ready();
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin mem[i] = 32'h0; shadow[i] = 32'h0; end
    t_reset();
    t_write(1'b0, 11'd4, 11'd1, 4'hF, 32'hA1B2_C3D4);
    t_read (1'b0, 11'd4, 11'd1, 4'hF);
    t_write(1'b1, 11'd3, 11'd2, 4'hF, 32'h1234_5678);
    t_write(1'b1, 11'd3, 11'd2, 4'b1100, 32'hDEAD_0000);
    t_read (1'b1, 11'd3, 11'd2, 4'hF);
    t_write(1'b0, 11'd6, 11'd3, 4'b0001, 32'h0000_00EE);
    t_read (1'b0, 11'd6, 11'd3, 4'hF);
    t_write(1'b1, 11'd7, 11'd0, 4'b0010, 32'h0000_5500);
    t_read (1'b1, 11'd7, 11'd0, 4'b0011);
    t_refresh();
    t_priority();
    t_no_interrupt();
    repeat (5) @(negedge clk);
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      finish_run();
    end
  end

endmodule